// File: doc/BRIEF.md
# Coalescing Store Buffer with Load Forwarding

This block sits between one processor and its cache or memory write port. The processor hands over a store (address, data, byte enables) through a valid/ready port. It continues as soon as the buffer takes the store. The buffer then writes its pending entries out to memory through a second valid/ready port, one entry at a time, in the order the entries were created.

A store to an address that already has a pending entry is folded into that entry. Its enabled bytes replace the old ones, and no new slot is used. The one exception is the entry currently shown to memory, which stays frozen; a store to that address opens a fresh entry. A combinational load lookup port reports whether the buffer holds every byte the load asks for, and returns the newest value of those bytes. A load can therefore finish ahead of older stores to other addresses.

Top module: `store_coalesce_buf`

## Requirements
- R1: Entries leave on the memory port in the order they were allocated, each carrying its address, its full data word and its byte enables.
- R2: A store is taken in the cycle where `st_valid` and `st_ready` are both high. `st_ready` never depends on `mem_ready`, so stores are taken while memory is stalled.
- R3: A store whose address matches a pending entry other than the one shown to memory replaces the bytes selected by its `st_be` in that entry and ORs its enables into the entry's enables. It allocates no slot and is accepted even when the buffer is full.
- R4: A store whose only matching entry is the one currently shown on the memory port allocates a new entry. When the buffer is full it is refused (`st_ready` low).
- R5: `ld_hit` and `ld_data` are combinational over all pending entries. Each byte comes from the newest entry holding that byte for `ld_addr`. Bytes that are not held read as zero.
- R6: `ld_hit` is high only when `ld_be` is non-zero and every byte selected by `ld_be` is held by some pending entry at `ld_addr`. Bit i of a byte-enable field covers data bits 8i+7..8i.
- R7: `full` is high when all DEPTH entries (default 8) are occupied, and `empty` is high when none are. While full, `st_ready` is high only for a store that can merge under R3.
- R8: Once `mem_valid` is high, it stays high and `mem_addr`, `mem_data` and `mem_be` stay unchanged until a cycle with `mem_ready` high.
- R9: After reset the buffer is empty: `empty`=1, `full`=0, `mem_valid`=0, `st_ready`=1.
- R10: A load may be satisfied by bytes spread over two pending entries to the same address, such as the frozen entry at the memory port and a newer one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_be | input | DATA_W/8 | Bytes the load needs |
| ld_hit | output | 1 | All needed bytes are buffered |
| ld_data | output | DATA_W | Newest buffered bytes at ld_addr |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | ADDR_W | Address of offered entry |
| mem_data | output | DATA_W | Data of offered entry |
| mem_be | output | DATA_W/8 | Byte enables of offered entry |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entries occupied |

## Verification
Stores are sent to distinct addresses, repeated addresses, the address of the entry held at the memory port, and split halves of one word. The drained stream then shows allocation apart from merging, and shows the frozen-entry rule at work. Loads are made with full, partial and absent byte coverage, which separates a true hit from a partial hit and from a miss, including coverage pieced together from two entries. A full buffer is tried with a fresh address, a mergeable address and the frozen address, which tells the three acceptance outcomes apart. Draining under held and alternating `mem_ready` checks both the hold rule and the exit order.

// File: rtl/scb_pkg.sv
package scb_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_MERGE = 2'd1,
      ACT_ALLOC = 2'd2,
      ACT_STALL = 2'd3
   } st_act_e;

   // position of the entry that is 'off' slots younger than 'base' in a ring
   function automatic int unsigned ring_idx(input int unsigned base,
                                            input int unsigned off,
                                            input int unsigned depth);
      int unsigned s;
      s = base + off;
      if (s >= depth) s = s - depth;
      return s;
   endfunction

endpackage

// File: rtl/scb_match.sv
module scb_match #(
   parameter int N      = 8,
   parameter int ADDR_W = 32
) (
   input  logic [N-1:0]             vld,
   input  logic [N-1:0][ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0]        key,
   output logic [N-1:0]             hit
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = vld[i] && (addr[i] == key);
   end
endmodule

// File: rtl/scb_pick.sv
module scb_pick #(
   parameter int N    = 8,
   parameter int PW   = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [PW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = PW'(i);
         end
      end
   end
endmodule

// File: rtl/scb_fwd.sv
module scb_fwd
   import scb_pkg::*;
#(
   parameter int N      = 8,
   parameter int DATA_W = 32,
   parameter int PW     = 3,
   localparam int BW    = DATA_W / 8
) (
   input  logic [N-1:0]             hit,
   input  logic [N-1:0][DATA_W-1:0] data,
   input  logic [N-1:0][BW-1:0]     be,
   input  logic [PW-1:0]            head,
   input  logic [BW-1:0]            ld_be,
   output logic                     ld_hit,
   output logic [DATA_W-1:0]        ld_data
);
   logic [BW-1:0] have;

   // oldest first, so younger entries overwrite the bytes they hold
   always_comb begin
      ld_data = '0;
      have    = '0;
      for (int i = 0; i < N; i++) begin
         int unsigned k;
         k = ring_idx(int'(head), i, N);
         if (hit[k]) begin
            for (int b = 0; b < BW; b++) begin
               if (be[k][b]) begin
                  ld_data[b*8 +: 8] = data[k][b*8 +: 8];
                  have[b]           = 1'b1;
               end
            end
         end
      end
      ld_hit = (ld_be != '0) && ((ld_be & ~have) == '0);
   end
endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf
   import scb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [BE_W-1:0]   st_be,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [BE_W-1:0]   ld_be,
   output logic              ld_hit,
   output logic [DATA_W-1:0] ld_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic [BE_W-1:0]   mem_be,
   output logic              full,
   output logic              empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("store_coalesce_buf: DATA_W must be a whole number of bytes");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("store_coalesce_buf: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0]             ent_v;
   logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
   logic [DEPTH-1:0][DATA_W-1:0] ent_data;
   logic [DEPTH-1:0][BE_W-1:0]   ent_be;
   logic [PTR_W-1:0]             head, tail, head_nx, tail_nx;
   logic [CNT_W-1:0]             cnt;

   logic [DEPTH-1:0] st_hit, ld_match, head_oh, st_cand;
   logic             cand_any;
   logic [PTR_W-1:0] cand_idx;
   st_act_e          act;
   logic             do_merge, do_alloc, drain;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_ptr_pow2
      assign head_nx = head + 1'b1;
      assign tail_nx = tail + 1'b1;
   end else begin : g_ptr_wrap
      assign head_nx = (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
      assign tail_nx = (tail == PTR_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
   end

   scb_match #(.N(DEPTH), .ADDR_W(ADDR_W)) u_st_match (
      .vld(ent_v), .addr(ent_addr), .key(st_addr), .hit(st_hit)
   );

   scb_match #(.N(DEPTH), .ADDR_W(ADDR_W)) u_ld_match (
      .vld(ent_v), .addr(ent_addr), .key(ld_addr), .hit(ld_match)
   );

   // the entry at the memory port is frozen; never merge into it
   assign head_oh = DEPTH'(1) << head;
   assign st_cand = st_hit & ~head_oh;

   scb_pick #(.N(DEPTH), .PW(PTR_W)) u_pick (
      .req(st_cand), .any(cand_any), .idx(cand_idx)
   );

   scb_fwd #(.N(DEPTH), .DATA_W(DATA_W), .PW(PTR_W)) u_fwd (
      .hit(ld_match), .data(ent_data), .be(ent_be), .head(head),
      .ld_be(ld_be), .ld_hit(ld_hit), .ld_data(ld_data)
   );

   assign full      = (cnt == CNT_W'(DEPTH));
   assign empty     = (cnt == '0);
   assign mem_valid = !empty;
   assign mem_addr  = ent_addr[head];
   assign mem_data  = ent_data[head];
   assign mem_be    = ent_be[head];
   assign drain     = mem_valid && mem_ready;

   always_comb begin
      if (!st_valid)     act = ACT_IDLE;
      else if (cand_any) act = ACT_MERGE;
      else if (!full)    act = ACT_ALLOC;
      else               act = ACT_STALL;
   end

   assign st_ready = cand_any || !full;
   assign do_merge = (act == ACT_MERGE);
   assign do_alloc = (act == ACT_ALLOC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v <= '0;
         head  <= '0;
         tail  <= '0;
         cnt   <= '0;
      end else begin
         if (drain) begin
            ent_v[head] <= 1'b0;
            head        <= head_nx;
         end
         if (do_alloc) begin
            ent_v[tail] <= 1'b1;
            tail        <= tail_nx;
         end
         cnt <= cnt + CNT_W'(do_alloc) - CNT_W'(drain);
      end
   end

   always_ff @(posedge clk) begin
      if (do_alloc) begin
         ent_addr[tail] <= st_addr;
         ent_data[tail] <= st_data;
         ent_be[tail]   <= st_be;
      end
      if (do_merge) begin
         for (int b = 0; b < BE_W; b++) begin
            if (st_be[b]) ent_data[cand_idx][b*8 +: 8] <= st_data[b*8 +: 8];
         end
         ent_be[cand_idx] <= ent_be[cand_idx] | st_be;
      end
   end

   // R8
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                     $stable(mem_data) && $stable(mem_be)));

   // R3
   merge_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && cand_any && !drain) |=> (cnt == $past(cnt)));

   // R2
   accept_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && !cand_any && !drain) |=> (cnt == $past(cnt) + 1'b1));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R3
   cand_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(st_cand));

endmodule

// File: tb/store_coalesce_buf_test.sv
module store_coalesce_buf_test;
   typedef struct packed {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
   } wr_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0, mem_ready = 1'b0;
   logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
   logic [3:0]  st_be = '0, ld_be = '0;
   logic        st_ready, ld_hit, mem_valid, full, empty;
   logic [31:0] ld_data, mem_addr, mem_data;
   logic [3:0]  mem_be;

   int   errors = 0, checks = 0;
   bit   done = 1'b0;
   wr_t  q[$];

   always #4 clk = ~clk;

   store_coalesce_buf uut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .ld_addr(ld_addr), .ld_be(ld_be), .ld_hit(ld_hit), .ld_data(ld_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_be(mem_be), .full(full), .empty(empty)
   );

   task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // driver: one store attempt; the model decides merge / allocate / refuse
   task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
      int  tgt;
      bit  exp_rdy;
      tgt = -1;
      for (int k = 1; k < q.size(); k++) if (q[k].a == a) tgt = k;
      exp_rdy = (tgt >= 0) || (q.size() < 8);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
      #1;
      chk(st_ready == exp_rdy, "R2/R3/R4/R7 st_ready", {71'd0, st_ready}, {71'd0, exp_rdy});
      if (exp_rdy) begin
         if (tgt >= 0) begin
            for (int b = 0; b < 4; b++) if (be[b]) q[tgt].d[b*8 +: 8] = d[b*8 +: 8];
            q[tgt].be = q[tgt].be | be;
         end else begin
            q.push_back('{a: a, d: d, be: be});
         end
      end
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic do_load(input logic [31:0] a, input logic [3:0] be, input string req);
      logic [31:0] ed;
      logic [3:0]  have;
      bit          eh;
      ed = '0; have = '0;
      foreach (q[k]) if (q[k].a == a)
         for (int b = 0; b < 4; b++) if (q[k].be[b]) begin
            ed[b*8 +: 8] = q[k].d[b*8 +: 8];
            have[b] = 1'b1;
         end
      eh = (be != 0) && ((be & ~have) == 0);
      @(negedge clk);
      ld_addr = a; ld_be = be;
      #1;
      chk(ld_hit == eh, {req, " ld_hit"}, {71'd0, ld_hit}, {71'd0, eh});
      chk(ld_data == ed, {req, " ld_data"}, {40'd0, ld_data}, {40'd0, ed});
   endtask

   task automatic drain_all(input bit toggle);
      int n;
      n = 0;
      while (q.size() != 0 && n < 200) begin
         @(negedge clk);
         mem_ready = toggle ? n[0] : 1'b1;
         n++;
      end
      @(negedge clk);
      mem_ready = 1'b0;
      #1;
      chk(q.size() == 0 && empty && !mem_valid, "R1/R7 drained empty", {71'd0, empty}, 72'd1);
   endtask

   // monitor: each memory handshake must match the oldest expected entry
   initial forever begin
      @(negedge clk); #1;
      if (rst_n && mem_valid && mem_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R1 unexpected write", {40'd0, mem_addr}, 72'd0);
         end else begin
            wr_t e;
            e = q.pop_front();
            chk(mem_addr == e.a && mem_data == e.d && mem_be == e.be, "R1 drain order",
                {mem_addr, mem_data, 4'd0, mem_be}, {e.a, e.d, 4'd0, e.be});
         end
      end
   end

   initial begin
      #(8 * 100000);
      chk(1'b0, "watchdog", 72'd0, 72'd1);
      finish_run();
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9
      chk(empty && !full && !mem_valid && st_ready, "R9 reset state",
          {68'd0, empty, full, mem_valid, st_ready}, {68'd0, 4'b1001});

      // distinct addresses, then merge into a younger entry (R3)
      do_store(32'h10, 32'h1111_1111, 4'hF);
      do_store(32'h20, 32'h2222_2222, 4'hF);
      do_store(32'h30, 32'h3333_3333, 4'hF);
      do_load(32'h20, 4'hF, "R5 full hit");
      do_load(32'h40, 4'hF, "R5 miss");
      do_store(32'h20, 32'hAAAA_BBBB, 4'h3);
      do_load(32'h20, 4'hF, "R3 merged bytes");
      // store to frozen head address allocates (R4)
      do_store(32'h10, 32'h5555_5555, 4'hF);
      do_load(32'h10, 4'hF, "R5 newest value");
      // partial coverage (R6)
      do_store(32'h50, 32'h0000_CDEF, 4'h3);
      do_load(32'h50, 4'hF, "R6 partial miss");
      do_load(32'h50, 4'h1, "R6 subset hit");
      do_load(32'h50, 4'h0, "R6 empty mask");
      do_store(32'h50, 32'h1234_0000, 4'hC);
      do_load(32'h50, 4'hF, "R3 combined");
      // held mem_ready: offered entry must not change (R8)
      held = mem_addr;
      repeat (3) @(negedge clk);
      #1;
      chk(mem_valid && mem_addr == held, "R8 hold", {40'd0, mem_addr}, {40'd0, held});
      drain_all(1'b0);

      // fill to capacity
      for (int i = 0; i < 8; i++) do_store(32'h100 + 32'(i * 4), 32'hC000_0000 + 32'(i), 4'hF);
      #1;
      chk(full && !empty, "R7 full flag", {70'd0, full, empty}, {70'd0, 2'b10});
      do_store(32'h200, 32'hDEAD_BEEF, 4'hF);   // R7 refused
      do_store(32'h104, 32'h0BAD_F00D, 4'hF);   // R3 merge while full
      do_store(32'h100, 32'hFFFF_FFFF, 4'hF);   // R4 refused, head is frozen
      do_load(32'h104, 4'hF, "R3 merged while full");
      drain_all(1'b1);

      // coverage split across frozen head and a younger entry (R10)
      do_store(32'h60, 32'h0000_0077, 4'h1);
      do_store(32'h60, 32'h0000_8800, 4'h2);
      do_load(32'h60, 4'h3, "R10 split hit");
      do_load(32'h60, 4'h7, "R10 split partial");
      drain_all(1'b1);

      finish_run();
   end
endmodule